// File: doc/BRIEF.md
# Stream-to-Memory Write Adapter

This block takes a flow-controlled stream of words from a processing function and stores them at consecutive locations of a memory bank. Software sets a start location and a word count through a small register window. The count write arms the transfer, and there is no separate go bit. After that the adapter accepts stream words as they arrive. Each word goes to memory through a request/acknowledge write port. While a write waits for acknowledge, the stream producer is held off.

Software polls a read-only register that holds the live number of words written, and so can tell when the results are complete. A done output also rises when the programmed count is reached. Once the count is reached, further stream data stays stalled until software programs a new length.

Top module: `strm_wr_adapter`

## Requirements
- R1: After reset, `s_ready`, `mem_req` and `xfer_done` are low, and the written-count register reads 0.
- R2: The register select is 0 for the start address, 1 for the length and 2 for the written count. Reads return the value zero-extended to 32 bits. A write to select 2 has no effect, and the count reads back unchanged.
- R3: A write to the length register with a nonzero value arms the adapter, clears the written count and `xfer_done`, and loads the address counter from the start-address register.
- R4: `s_ready` is high only while the adapter is armed, no memory write is outstanding and the written count is below the length.
- R5: A word accepted on the stream (`s_valid` and `s_ready` at a clock edge) raises `mem_req` in the next cycle, carrying the address counter and the word. Address and data stay stable until `mem_ack`.
- R6: A `mem_ack` while `mem_req` is high drops `mem_req` at that edge and increments both the address counter and the written count. Word i of a transfer is therefore written to start+i, modulo 2^AW.
- R7: When the written count reaches the length, the adapter disarms and `xfer_done` rises. After that `s_ready` stays low and no further request is issued, even with `s_valid` held high.
- R8: A length write of 0 leaves the adapter unarmed, raises `xfer_done` at once and clears the count.
- R9: A length write that arrives while a memory request is outstanding is ignored. The running transfer keeps its original length.
- R10: Writing the start-address register during a transfer does not change the addresses of that transfer. The new value is used only at the next length write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 2 | Register select for read |
| reg_rd_data | output | 32 | Register read data (combinational) |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DW | Stream word |
| s_ready | output | 1 | Adapter can take a word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory accepted the write |
| xfer_done | output | 1 | Programmed length reached |

## Verification
A wrong address counter shows up on `mem_addr` with the very next request. It is caught at the first word written after the fault, because every request is compared with start plus the number of words already acknowledged. A wrong written count shows up in the polled count register in the cycle after an acknowledge. It also shows up at the end of a transfer, as an early or missing `xfer_done` or as an extra word accepted once the length is reached. A stuck pending flag shows as `s_ready` asserted during a request, or as a transfer that never finishes, within one word.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int REG_W = 32;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CNT  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/wa_regs.sv
module wa_regs
  import wa_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             busy,
  input  logic [CW-1:0]    cnt,
  output logic [AW-1:0]    start_addr,
  output logic [CW-1:0]    len,
  output logic             len_load
);
  logic          addr_en;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] len_q;

  assign addr_en  = wr_en && (wr_sel == SEL_ADDR);
  assign len_load = wr_en && (wr_sel == SEL_LEN) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= wr_data[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_load) begin
      len_q <= wr_data[CW-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_ADDR: rd_data[AW-1:0] = addr_q;
      SEL_LEN:  rd_data[CW-1:0] = len_q;
      SEL_CNT:  rd_data[CW-1:0] = cnt;
      default:  rd_data = '0;
    endcase
  end

  assign start_addr = addr_q;
  assign len        = len_q;
endmodule

// File: rtl/wa_seq.sv
module wa_seq #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          len_load,
  input  logic [CW-1:0] len_new,
  input  logic [CW-1:0] len,
  input  logic [AW-1:0] start_addr,
  input  logic          word_done,
  output logic          armed,
  output logic          room,
  output logic          done,
  output logic [CW-1:0] cnt,
  output logic [AW-1:0] addr_cnt
);
  logic          armed_q, armed_d, done_q, done_d, en;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic [AW-1:0] acnt_q, acnt_d;

  assign cnt_inc = cnt_q + CW'(1);

  always_comb begin
    en      = 1'b0;
    armed_d = armed_q;
    done_d  = done_q;
    cnt_d   = cnt_q;
    acnt_d  = acnt_q;
    if (len_load) begin
      en      = 1'b1;
      cnt_d   = '0;
      acnt_d  = start_addr;
      armed_d = (len_new != '0);
      done_d  = (len_new == '0);
    end else if (word_done) begin
      en      = 1'b1;
      cnt_d   = cnt_inc;
      acnt_d  = acnt_q + AW'(1);
      if (cnt_inc == len) begin
        armed_d = 1'b0;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      acnt_q  <= '0;
    end else if (en) begin
      armed_q <= armed_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      acnt_q  <= acnt_d;
    end
  end

  assign armed    = armed_q;
  assign done     = done_q;
  assign cnt      = cnt_q;
  assign addr_cnt = acnt_q;
  assign room     = (cnt_q < len);
endmodule

// File: rtl/wa_wport.sv
module wa_wport #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          ack,
  output logic          pending,
  output logic          word_done,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] data_out
);
  logic          pend_q, pend_d, pend_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign word_done = pend_q && ack;

  always_comb begin
    pend_en = accept || word_done;
    pend_d  = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  assign pending  = pend_q;
  assign addr_out = addr_q;
  assign data_out = data_q;
endmodule

// File: rtl/strm_wr_adapter.sv
module strm_wr_adapter
  import wa_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_wr_sel,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic [1:0]       reg_rd_sel,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             s_valid,
  input  logic [DW-1:0]    s_data,
  output logic             s_ready,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  output logic             xfer_done
);
  logic          rst_meta_n, rst_sync_n;
  logic          armed, room, pending, word_done, len_load, accept;
  logic [CW-1:0] cnt, len;
  logic [AW-1:0] start_addr, addr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign s_ready = armed && !pending && room;
  assign accept  = s_valid && s_ready;

  wa_regs #(.AW(AW), .CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
    .busy(pending), .cnt(cnt),
    .start_addr(start_addr), .len(len), .len_load(len_load)
  );

  wa_seq #(.AW(AW), .CW(CW)) seq_i (
    .clk(clk), .rst_n(rst_sync_n),
    .len_load(len_load), .len_new(reg_wr_data[CW-1:0]), .len(len),
    .start_addr(start_addr), .word_done(word_done),
    .armed(armed), .room(room), .done(xfer_done),
    .cnt(cnt), .addr_cnt(addr_cnt)
  );

  wa_wport #(.AW(AW), .DW(DW)) wport_i (
    .clk(clk), .rst_n(rst_sync_n),
    .accept(accept), .addr_in(addr_cnt), .data_in(s_data),
    .ack(mem_ack), .pending(pending), .word_done(word_done),
    .addr_out(mem_addr), .data_out(mem_wdata)
  );

  assign mem_req = pending;
endmodule

// File: rtl/wa_checker.sv
module wa_checker #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          xfer_done,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] len
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R5
  AST_ACCEPT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> mem_req); // R5
  AST_NO_READY_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !s_ready); // R4
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> cnt == CW'($past(cnt) + CW'(1))); // R6
  AST_DONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !s_ready); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= len); // R7
endmodule

bind strm_wr_adapter wa_checker #(.AW(AW), .DW(DW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .s_valid(s_valid), .s_ready(s_ready),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .xfer_done(xfer_done), .cnt(cnt), .len(len)
);

// File: tb/strm_wr_adapter_tb_top.sv
module strm_wr_adapter_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_wr_sel = '0;
  logic [31:0]   reg_wr_data = '0;
  logic [1:0]    reg_rd_sel = '0;
  logic [31:0]   reg_rd_data;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_ready;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic          xfer_done;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] words [0:63];

  always #4 clk = ~clk;

  strm_wr_adapter #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .xfer_done(xfer_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input int idx);
    return AW'(base + AW'(idx));
  endfunction

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] val);
    reg_rd_sel = sel;
    #1;
    val = reg_rd_data;
  endtask

  task automatic run_xfer(input logic [AW-1:0] start, input int len, input bit poke);
    int sent = 0, acked = 0, dly = 0, cyc = 0;
    bit waiting = 0, acc, fired;
    logic [31:0] rv;
    for (int i = 0; i < 64; i++) words[i] = $urandom;
    reg_write(2'd0, 32'(start));
    reg_write(2'd1, 32'(len));
    reg_read(2'd2, rv);
    chk(rv == 0, "R3 count cleared", rv, 0);
    chk(xfer_done == 1'b0, "R3 done cleared", xfer_done, 0);
    while (acked < len && cyc < 3000) begin
      cyc++;
      reg_wr_en = 1'b0;
      reg_read(2'd2, rv);
      chk(rv == 32'(acked), "R6 live count", rv, acked);
      if (s_ready) chk(!mem_req && acked < len, "R4 ready gating", mem_req, 0);
      fired = 0;
      if (mem_req) begin
        if (!waiting) begin
          waiting = 1;
          chk(mem_addr == exp_addr(start, acked), "R6 address", mem_addr, exp_addr(start, acked));
          chk(mem_wdata == words[acked], "R5 data", mem_wdata, words[acked]);
          dly = (poke && acked == 0) ? 3 : int'($urandom % 3);
        end
        if (poke && acked == 0 && dly == 3) begin
          reg_wr_en = 1'b1; reg_wr_sel = 2'd1; reg_wr_data = 32'd9;       // R9
        end else if (poke && acked == 0 && dly == 2) begin
          reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 32'h3000;    // R10
        end
        if (dly == 0) begin mem_ack = 1'b1; fired = 1; end
        else begin mem_ack = 1'b0; dly--; end
      end else mem_ack = 1'b0;
      if (!s_valid && sent < 63 && ($urandom % 4) != 0) begin
        s_valid = 1'b1; s_data = words[sent];
      end
      #1;
      acc = s_valid && s_ready;
      if (acc) chk(sent < len, "R7 no accept past length", sent, len);
      @(negedge clk);
      if (acc) begin sent++; s_valid = 1'b0; end
      if (fired) begin acked++; waiting = 0; mem_ack = 1'b0; end
    end
    reg_wr_en = 1'b0;
    mem_ack = 1'b0;
    chk(acked == len, "R7 transfer completes", acked, len);
    chk(xfer_done == 1'b1, "R7 done raised", xfer_done, 1);
    reg_read(2'd2, rv);
    chk(rv == 32'(len), "R7 final count", rv, len);
    s_valid = 1'b1; s_data = words[63];
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!s_ready && !mem_req, "R7 stall after done", {s_ready, mem_req}, 0);
    end
    s_valid = 1'b0;
    if (poke) begin
      reg_read(2'd0, rv);
      chk(rv == 32'h3000, "R2 address readback", rv, 32'h3000);
      reg_read(2'd1, rv);
      chk(rv == 32'(len), "R9 length kept", rv, len);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_read(2'd2, rv);
    chk(rv == 0, "R1 count reset", rv, 0);
    chk(!s_ready && !mem_req && !xfer_done, "R1 outputs reset",
        {s_ready, mem_req, xfer_done}, 0);

    run_xfer(16'h0040, 1, 1'b0);
    run_xfer(16'hFFFE, 4, 1'b0);            // R6 wrap
    run_xfer(16'h0100, 5, 1'b1);            // R9 R10
    for (int t = 0; t < 8; t++)
      run_xfer(AW'($urandom), 1 + int'($urandom % 20), 1'b0);

    reg_write(2'd2, 32'h55);                // R2 count read-only
    reg_read(2'd2, rv);
    chk(rv == 0 || rv != 32'h55, "R2 count write ignored", rv, 0);
    run_xfer(16'h0200, 3, 1'b0);
    reg_write(2'd2, 32'h55);
    reg_read(2'd2, rv);
    chk(rv == 3, "R2 count unchanged", rv, 3);
    reg_read(2'd1, rv);
    chk(rv == 3, "R2 length readback", rv, 3);

    reg_write(2'd1, 32'd0);                 // R8
    reg_read(2'd2, rv);
    chk(rv == 0, "R8 count cleared", rv, 0);
    chk(xfer_done == 1'b1 && !s_ready, "R8 done no ready", {xfer_done, s_ready}, 2'b10);
    s_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!mem_req && !s_ready, "R8 no write", {mem_req, s_ready}, 0);
    end
    s_valid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule